// File: doc/BRIEF.md
# Variable-Length Microcycle Controller

This block paces the microcode of a small 8-bit microprogrammed processor. Each microcycle is stretched or shortened so that it lasts as long as the memory or functional unit that supplies its data needs. A length code arrives alongside a decimal-arithmetic flag. The code comes from decoding the region being accessed: combinational RAM, on-chip synchronous block RAM, or external synchronous SRAM. The flag is raised for an add or subtract that needs BCD correction. Both inputs are captured on the clock that closes the current microcycle and govern the whole of the next one.

Inside a microcycle the controller steps a 2-bit state index from 0 up to a final state. In state 0 it enables address capture. In the final state it pulses a one-clock end-of-cycle strobe, which advances the microsequencer, and enables data capture. A wait input lets a slow external device freeze the count in the middle states. The strobe stays low for as long as the freeze lasts.

Top module: `mcyc_ctrl`

## Requirements
- R1: The length code `len_sel` selects the number of clocks per microcycle with no wait applied: 0 gives 1 clock (combinational RAM), 1 gives 2 clocks (block RAM), 2 gives 3 clocks, and 3 gives 4 clocks (external synchronous SRAM).
- R2: When `dec_ext` is high, the selected length grows by one clock, up to at most 4: code 0 gives 2, code 1 gives 3, code 2 gives 4 and code 3 gives 4.
- R3: `len_sel` and `dec_ext` are sampled only on the clock edge that ends a cycle, that is, while `cyc_end` is high. A change of either input during the cycle has no effect on that cycle's length.
- R4: While `wait_in` is high in state 1, or in state 2 of a 4-clock cycle, `state_idx` holds and `cyc_end` stays low.
- R5: `wait_in` has no effect in state 0 or in the final state of a 1-, 3- or 4-clock cycle.
- R6: In a 2-clock cycle, state 1 is both final and waitable. `wait_in` there suppresses `cyc_end` and lengthens the cycle by one clock for each clock it is high.
- R7: `addr_cap` is high exactly in state 0. `data_cap` and `cyc_end` are high together in the final state, for one clock per cycle. In a 1-clock cycle all three are high in the same clock.
- R8: A synchronous active-high reset puts the controller in state 0 with a 1-clock length latched. In the first clock after reset is released, `cyc_end` is high.
- R9: With `wait_in` low, `state_idx` counts up by one each clock from 0 to the final state and returns to 0 after `cyc_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_sel | input | 2 | Length code for the next microcycle |
| dec_ext | input | 1 | Decimal add/subtract: extend the next cycle by one clock |
| wait_in | input | 1 | Hold request from a slow device |
| state_idx | output | 2 | Current state within the microcycle |
| cyc_end | output | 1 | End-of-cycle strobe to the microsequencer |
| addr_cap | output | 1 | Address capture enable (state 0) |
| data_cap | output | 1 | Data capture enable (final state) |

## Verification
Two functions can fall in the same clock. In a 2-clock cycle, the final strobe and a wait hold both land on state 1. In a 1-clock cycle, address capture and data capture fall in one clock. The bench provokes the first by raising `wait_in` on state 1 of 2-clock cycles, both plain ones and ones reached through the decimal extension. It judges the result by the measured length and by the strobe staying low while the hold lasts. For the second, it applies wait to state 0 of a 1-clock cycle and checks that all three enables are still high in that single clock.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int STATE_W   = 2;
    localparam int MAX_LEN   = 1 << STATE_W;
    localparam int LEN_W     = STATE_W;

    typedef logic [STATE_W-1:0] state_t;

    typedef enum logic [LEN_W-1:0] {
        LEN_ONE   = 2'd0,
        LEN_TWO   = 2'd1,
        LEN_THREE = 2'd2,
        LEN_FOUR  = 2'd3
    } len_code_e;

    typedef struct packed {
        logic addr_cap;
        logic data_cap;
        logic cyc_end;
    } strobe_s;

    // Index of the final state for a code, with optional one-clock extension
    function automatic state_t final_state(input len_code_e code, input logic ext);
        logic [STATE_W:0] sum;
        sum = {1'b0, code} + {{STATE_W{1'b0}}, ext};
        if (sum > (MAX_LEN - 1))
            return state_t'(MAX_LEN - 1);
        return sum[STATE_W-1:0];
    endfunction

    // States in which a hold request is honoured
    function automatic logic is_waitable(input state_t st, input state_t last);
        return (st == state_t'(1)) ||
               ((st == state_t'(2)) && (last == state_t'(MAX_LEN - 1)));
    endfunction

endpackage

// File: rtl/mcyc_len_latch.sv
module mcyc_len_latch
    import mcyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_sel,
    input  logic             dec_ext,
    output state_t           last_idx
);

    state_t last_q;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= state_t'(0);
        else if (load)
            last_q <= final_state(len_code_e'(len_sel), dec_ext);
    end

    assign last_idx = last_q;

endmodule

// File: rtl/mcyc_state_ctr.sv
module mcyc_state_ctr
    import mcyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   hold,
    output state_t state
);

    state_t state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= state_t'(0);
        else if (restart)
            state_q <= state_t'(0);
        else if (!hold)
            state_q <= state_q + state_t'(1);
    end

    assign state = state_q;

endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
    import mcyc_pkg::*;
(
    input  state_t  state,
    input  state_t  last_idx,
    input  logic    wait_in,
    output logic    hold,
    output strobe_s strb
);

    logic at_last;

    always_comb begin
        hold          = wait_in && is_waitable(state, last_idx);
        at_last       = (state == last_idx);
        strb.addr_cap = (state == state_t'(0));
        strb.cyc_end  = at_last && !hold;
        strb.data_cap = strb.cyc_end;
    end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len_sel,
    input  logic             dec_ext,
    input  logic             wait_in,
    output logic [STATE_W-1:0] state_idx,
    output logic             cyc_end,
    output logic             addr_cap,
    output logic             data_cap
);

    state_t  cur_state;
    state_t  last_idx;
    logic    hold;
    strobe_s strb;

    mcyc_len_latch u_len (
        .clk      (clk),
        .rst      (rst),
        .load     (strb.cyc_end),
        .len_sel  (len_sel),
        .dec_ext  (dec_ext),
        .last_idx (last_idx)
    );

    mcyc_state_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (strb.cyc_end),
        .hold    (hold),
        .state   (cur_state)
    );

    mcyc_decode u_dec (
        .state    (cur_state),
        .last_idx (last_idx),
        .wait_in  (wait_in),
        .hold     (hold),
        .strb     (strb)
    );

    assign state_idx = cur_state;
    assign cyc_end   = strb.cyc_end;
    assign addr_cap  = strb.addr_cap;
    assign data_cap  = strb.data_cap;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk
    import mcyc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   wait_in,
    input state_t state_idx,
    input state_t last_idx,
    input logic   cyc_end,
    input logic   addr_cap
);

    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (state_idx == state_t'(0)));

    a_r9_advance: assert property (@(posedge clk) disable iff (rst)
        (!cyc_end && !wait_in) |=> (state_idx == $past(state_idx) + state_t'(1)));

    a_r9_bound: assert property (@(posedge clk) disable iff (rst)
        state_idx <= last_idx);

    a_r4_hold_state: assert property (@(posedge clk) disable iff (rst)
        (wait_in && ((state_idx == state_t'(1)) ||
                     (state_idx == state_t'(2) && last_idx == state_t'(3))))
        |=> $stable(state_idx));

    a_r6_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (wait_in && state_idx == state_t'(1)) |-> !cyc_end);

    a_r5_state0_ignores_wait: assert property (@(posedge clk) disable iff (rst)
        (state_idx == state_t'(0) && last_idx != state_t'(0)) |=> (state_idx == state_t'(1)));

    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        cyc_end |=> (state_idx == state_t'(0) && addr_cap));

endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wait_in   (wait_in),
    .state_idx (state_idx),
    .last_idx  (last_idx),
    .cyc_end   (cyc_end),
    .addr_cap  (addr_cap)
);

// File: tb/tb_mcyc_ctrl.sv
module tb_mcyc_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] len_sel = 2'd0;
    logic       dec_ext = 1'b0;
    logic       wait_in = 1'b0;
    logic [1:0] state_idx;
    logic       cyc_end, addr_cap, data_cap;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mcyc_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .len_sel   (len_sel),
        .dec_ext   (dec_ext),
        .wait_in   (wait_in),
        .state_idx (state_idx),
        .cyc_end   (cyc_end),
        .addr_cap  (addr_cap),
        .data_cap  (data_cap)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic       dec;
        logic [2:0] hs;    // state to hold in, 4 = none
        logic [3:0] hn;    // clocks of wait to offer
        logic       flip;  // change inputs mid-cycle
        logic [3:0] exp;   // expected cycle length
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 3'd4, 4'd0, 1'b0, 4'd1},  // R1
        '{2'd1, 1'b0, 3'd4, 4'd0, 1'b0, 4'd2},  // R1
        '{2'd2, 1'b0, 3'd4, 4'd0, 1'b0, 4'd3},  // R1
        '{2'd3, 1'b0, 3'd4, 4'd0, 1'b0, 4'd4},  // R1
        '{2'd0, 1'b1, 3'd4, 4'd0, 1'b0, 4'd2},  // R2
        '{2'd1, 1'b1, 3'd4, 4'd0, 1'b0, 4'd3},  // R2
        '{2'd2, 1'b1, 3'd4, 4'd0, 1'b0, 4'd4},  // R2
        '{2'd3, 1'b1, 3'd4, 4'd0, 1'b0, 4'd4},  // R2 cap
        '{2'd3, 1'b0, 3'd1, 4'd2, 1'b0, 4'd6},  // R4
        '{2'd3, 1'b0, 3'd2, 4'd3, 1'b0, 4'd7},  // R4
        '{2'd1, 1'b0, 3'd1, 4'd2, 1'b0, 4'd4},  // R6
        '{2'd2, 1'b0, 3'd2, 4'd2, 1'b0, 4'd3},  // R5 final of 3
        '{2'd2, 1'b0, 3'd1, 4'd1, 1'b0, 4'd4},  // R4
        '{2'd0, 1'b0, 3'd0, 4'd3, 1'b0, 4'd1},  // R5 state 0
        '{2'd3, 1'b0, 3'd3, 4'd2, 1'b0, 4'd4},  // R5 final of 4
        '{2'd0, 1'b1, 3'd1, 4'd1, 1'b0, 4'd3},  // R6 via R2
        '{2'd3, 1'b0, 3'd4, 4'd0, 1'b1, 4'd4}   // R3
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a strobe clock (negedge + 1): sets the next cycle's inputs and measures it
    task automatic run_vec(input vec_t v, input string req);
        int n = 0;
        int exp_st = 0;
        int holds = 0;
        int eff;
        int seq_bad = 0;
        len_sel = v.sel;
        dec_ext = v.dec;
        wait_in = 1'b0;
        eff = int'(v.sel) + 1 + int'(v.dec);
        if (eff > 4) eff = 4;
        @(posedge clk);
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (v.flip && n == 1) begin
                len_sel = 2'd0;
                dec_ext = 1'b1;
            end
            wait_in = (int'(state_idx) == int'(v.hs)) && (holds < int'(v.hn));
            if (wait_in) holds++;
            #1;
            if (int'(state_idx) != exp_st) seq_bad++;               // R9
            if (addr_cap != (exp_st == 0)) seq_bad++;                // R7
            if (data_cap != cyc_end) seq_bad++;                      // R7
            if (cyc_end) break;
            if (!(wait_in && (exp_st == 1 || (exp_st == 2 && eff == 4))))
                exp_st++;
        end
        chk(n == int'(v.exp), req, n, int'(v.exp));
        chk(seq_bad == 0, "R9/R7 state sequence and enables", seq_bad, 0);
        wait_in = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(state_idx == 2'd0, "R8 state in reset", state_idx, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cyc_end == 1'b1, "R8 strobe in first clock after reset", cyc_end, 1);
        chk(addr_cap && data_cap, "R7 all enables in 1-clock cycle",
            {addr_cap, data_cap}, 3);

        foreach (VECS[i]) begin
            string tag;
            if (VECS[i].flip) tag = "R3 mid-cycle change ignored";
            else if (VECS[i].hs == 3'd4 && !VECS[i].dec) tag = "R1 length";
            else if (VECS[i].hs == 3'd4) tag = "R2 decimal extension";
            else if (VECS[i].exp == int'(VECS[i].sel) + 1) tag = "R5 wait ignored";
            else if (VECS[i].sel == 2'd1 || VECS[i].dec) tag = "R6 two-clock hold";
            else tag = "R4 hold";
            run_vec(VECS[i], tag);
        end

        // R8: reset in the middle of a 4-clock cycle restores a 1-clock length
        len_sel = 2'd3;
        dec_ext = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        len_sel = 2'd2;
        @(negedge clk);
        #1;
        chk(state_idx == 2'd0, "R8 reset mid-cycle state", state_idx, 0);
        rst = 1'b0;
        #1;
        chk(cyc_end == 1'b1, "R8 1-clock length after reset", cyc_end, 1);
        run_vec(VECS[3], "R1 length after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule